// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a simple 32-bit in-order core and works out, every cycle, where execution goes next. It looks at the current instruction word and at the two source register values that the register file reads for it. From these it picks one of four next addresses: the address that follows in sequence, a jump target built from the instruction, a relative branch target, or an address taken from a register. A branch or jump redirects the very next fetch. No delay slot exists, so the instruction after a taken branch is never executed.

For the linking jumps the unit also produces a write request for the register file. The request carries the destination index and the return address, which is the address that follows the jump. The return address is formed from the current PC, not from a register value. A register-indirect jump that names the same register for its target and its link therefore jumps to the old register value and still links correctly. If a register-indirect jump targets an address that is not word aligned, the unit raises a fault flag, cancels the link write and keeps the PC where it is.

Top module: `npc_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `pcOut` is 0x00001000.
- R2: For any instruction outside the flow-control set, `nextPc` is `pcOut`+4 and `linkWe` is 0. The flow-control set is: opcode 0x2, 0x3, 0x4 and 0x5, plus opcode 0x0 with funct 0x08 or 0x09. Opcode is `instr[31:26]` and funct is `instr[5:0]`.
- R3: For opcode 0x2 (jump) and 0x3 (jump-and-link), `nextPc` is built from three parts, from high to low. The top 4 bits are taken from bits [31:28] of `pcOut`+4. The middle bits are `instr[25:0]`. The two lowest bits are 00.
- R4: For opcode 0x3, `linkWe` is 1, `linkIdx` is 31 and `linkVal` is `pcOut`+4.
- R5: For opcode 0x4, if `rsVal` equals `rtVal`, `nextPc` is `pcOut`+4 plus the sign-extended `instr[15:0]` times 4. Otherwise `nextPc` is `pcOut`+4. `linkWe` is 0 in both cases.
- R6: For opcode 0x5, the same targets as R5 apply, but the branch is taken when `rsVal` differs from `rtVal`.
- R7: For opcode 0x0 with funct 0x08 or 0x09, when `rsVal[1:0]` is 00, `nextPc` is `rsVal`. Funct 0x08 raises no link write.
- R8: For opcode 0x0 with funct 0x09 and an aligned `rsVal`, `linkWe` is 1, `linkIdx` is `instr[15:11]` and `linkVal` is `pcOut`+4. This holds even when `instr[15:11]` equals `instr[25:21]`.
- R9: For opcode 0x0 with funct 0x08 or 0x09, when `rsVal[1:0]` is not 00, the following all hold:
  - `misalignFault` is 1;
  - `linkWe` is 0;
  - `nextPc` equals `pcOut`;
  - `pcOut` is unchanged after the next edge.
- R10: On each rising clock edge out of reset, `pcOut` takes the `nextPc` value of the cycle before. A taken branch or jump is therefore the very next PC, with no delay slot.
- R11: `misalignFault` is 0 for every instruction other than opcode 0x0 with funct 0x08 or 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word being executed |
| rsVal | input | 32 | Value of the register named by instr[25:21] |
| rtVal | input | 32 | Value of the register named by instr[20:16] |
| pcOut | output | 32 | Current program counter |
| nextPc | output | 32 | Address of the next instruction |
| linkWe | output | 1 | Return-address write request |
| linkIdx | output | 5 | Destination register for the return address |
| linkVal | output | 32 | Return address (current PC + 4) |
| misalignFault | output | 1 | Register jump to a non-word-aligned address |

## Verification
`nextPc`, `linkWe`, `linkIdx`, `linkVal` and `misalignFault` are combinational functions of `pcOut` and the inputs. They are due in the same cycle that the stimulus is applied. `pcOut` is due one rising edge later. The bench drives each instruction just after a falling edge and samples the combinational outputs a nanosecond later. It then waits through the next rising edge and checks `pcOut` at the following falling edge against the next PC that its own model predicted. A PC that holds on a fault and a target whose top nibble is reached through a register jump are both followed across edges in this way.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JUMP    = 6'h02;
  localparam logic [5:0] OP_JLINK   = 6'h03;
  localparam logic [5:0] OP_BREQ    = 6'h04;
  localparam logic [5:0] OP_BRNE    = 6'h05;
  localparam logic [5:0] FN_JREG    = 6'h08;
  localparam logic [5:0] FN_JREGLNK = 6'h09;

  typedef enum logic [1:0] {
    TGT_SEQ,
    TGT_JUMP,
    TGT_BRANCH,
    TGT_REG
  } tgtSel_e;

  typedef struct packed {
    tgtSel_e sel;
    logic    cmpEq;
    logic    cmpNe;
    logic    linkEn;
    logic    linkToRd;
  } npcStrobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output npcStrobe_t  strobe
);

  always_comb begin
    strobe = '{sel: TGT_SEQ, cmpEq: 1'b0, cmpNe: 1'b0, linkEn: 1'b0, linkToRd: 1'b0};
    unique case (opcode)
      OP_JUMP: strobe.sel = TGT_JUMP;
      OP_JLINK: begin
        strobe.sel    = TGT_JUMP;
        strobe.linkEn = 1'b1;
      end
      OP_BREQ: begin
        strobe.sel   = TGT_BRANCH;
        strobe.cmpEq = 1'b1;
      end
      OP_BRNE: begin
        strobe.sel   = TGT_BRANCH;
        strobe.cmpNe = 1'b1;
      end
      OP_SPECIAL: begin
        if (funct == FN_JREG) begin
          strobe.sel = TGT_REG;
        end else if (funct == FN_JREGLNK) begin
          strobe.sel      = TGT_REG;
          strobe.linkEn   = 1'b1;
          strobe.linkToRd = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          IDX_W    = 5,
  parameter int          IMM_W    = 16,
  parameter int          JFLD_W   = 26,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int          LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  npcStrobe_t        strobe,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JFLD_W-1:0] jField,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   nextPc,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [XLEN-1:0]   linkVal,
  output logic              misalignFault
);

  localparam int          ALIGN_W  = 2;
  localparam int          REGION_W = XLEN - JFLD_W - ALIGN_W;
  localparam int          SEXT_W   = XLEN - IMM_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] pcPlus4;
  logic [XLEN-1:0] branchOfs;
  logic [XLEN-1:0] branchTgt;
  logic [XLEN-1:0] jumpTgt;
  logic [XLEN-1:0] chosenTgt;
  logic            operandsEq;
  logic            takeBranch;

  assign pcPlus4    = pcReg + STEP;
  assign branchOfs  = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
  assign branchTgt  = pcPlus4 + branchOfs;
  assign jumpTgt    = {pcPlus4[XLEN-1 -: REGION_W], jField, {ALIGN_W{1'b0}}};
  assign operandsEq = (rsVal == rtVal);
  assign takeBranch = (strobe.cmpEq & operandsEq) | (strobe.cmpNe & ~operandsEq);

  always_comb begin
    unique case (strobe.sel)
      TGT_JUMP:   chosenTgt = jumpTgt;
      TGT_BRANCH: chosenTgt = takeBranch ? branchTgt : pcPlus4;
      TGT_REG:    chosenTgt = rsVal;
      default:    chosenTgt = pcPlus4;
    endcase
  end

  assign misalignFault = (strobe.sel == TGT_REG) && (rsVal[ALIGN_W-1:0] != '0);
  assign nextPc        = misalignFault ? pcReg : chosenTgt;

  assign linkWe  = strobe.linkEn & ~misalignFault;
  assign linkIdx = strobe.linkToRd ? rdIdx : IDX_W'(LINK_REG);
  assign linkVal = pcPlus4;

  always_ff @(posedge clk) begin
    if (!rstN) pcReg <= RESET_PC[XLEN-1:0];
    else       pcReg <= nextPc;
  end

  assign pcOut = pcReg;

endmodule

// File: rtl/npc_top.sv
module npc_top
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          IDX_W    = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  parameter int          LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   nextPc,
  output logic              linkWe,
  output logic [IDX_W-1:0]  linkIdx,
  output logic [XLEN-1:0]   linkVal,
  output logic              misalignFault
);

  localparam int IMM_W  = 16;
  localparam int JFLD_W = 26;
  localparam int RD_LSB = 11;

  npcStrobe_t strobe;

  npc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .strobe (strobe)
  );

  npc_dpath #(
    .XLEN     (XLEN),
    .IDX_W    (IDX_W),
    .IMM_W    (IMM_W),
    .JFLD_W   (JFLD_W),
    .RESET_PC (RESET_PC),
    .LINK_REG (LINK_REG)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .imm           (instr[IMM_W-1:0]),
    .jField        (instr[JFLD_W-1:0]),
    .rdIdx         (instr[RD_LSB +: IDX_W]),
    .rsVal         (rsVal),
    .rtVal         (rtVal),
    .pcOut         (pcOut),
    .nextPc        (nextPc),
    .linkWe        (linkWe),
    .linkIdx       (linkIdx),
    .linkVal       (linkVal),
    .misalignFault (misalignFault)
  );

endmodule

// File: rtl/npc_chk.sv
module npc_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       opc,
  input logic [5:0]       fn,
  input logic [XLEN-1:0]  rsVal,
  input logic [XLEN-1:0]  pcOut,
  input logic [XLEN-1:0]  nextPc,
  input logic             linkWe,
  input logic [IDX_W-1:0] linkIdx,
  input logic [XLEN-1:0]  linkVal,
  input logic             misalignFault
);

  logic isRegJump;
  logic isFlow;
  assign isRegJump = (opc == 6'h00) && (fn == 6'h08 || fn == 6'h09);
  assign isFlow    = isRegJump || (opc inside {6'h02, 6'h03, 6'h04, 6'h05});

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isFlow |-> (nextPc == pcOut + 32'd4) && !linkWe);

  // R4
  jal_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opc == 6'h03) |-> linkWe && (linkIdx == 5'd31) && (linkVal == pcOut + 32'd4));

  // R9
  hold_on_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (misalignFault && $past(rstN)) |=> $stable(pcOut));

  // R9
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> (rsVal[1:0] != 2'b00) && !linkWe);

  // R11
  fault_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    misalignFault |-> isRegJump);

  // R10
  pc_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcOut[1:0] == 2'b00);

endmodule

bind npc_top npc_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .opc           (instr[31:26]),
  .fn            (instr[5:0]),
  .rsVal         (rsVal),
  .pcOut         (pcOut),
  .nextPc        (nextPc),
  .linkWe        (linkWe),
  .linkIdx       (linkIdx),
  .linkVal       (linkVal),
  .misalignFault (misalignFault)
);

// File: tb/sim_npc_top.sv
module sim_npc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rsVal = 32'h0;
  logic [31:0] rtVal = 32'h0;
  logic [31:0] pcOut, nextPc, linkVal;
  logic        linkWe, misalignFault;
  logic [4:0]  linkIdx;

  int          nChecks = 0;
  int          nFails  = 0;
  logic [31:0] modelPc = 32'h0000_1000;
  bit          done    = 1'b0;

  always #4 clk = ~clk;

  npc_top u0 (
    .clk(clk), .rstN(rstN), .instr(instr), .rsVal(rsVal), .rtVal(rtVal),
    .pcOut(pcOut), .nextPc(nextPc), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkVal(linkVal), .misalignFault(misalignFault)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] pc, input logic [31:0] ins,
                                input logic [31:0] rs, input logic [31:0] rt,
                                output logic [31:0] nxt, output logic we,
                                output logic [4:0] idx, output logic flt,
                                output string tag);
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [31:0] p4 = pc + 32'd4;
    logic [31:0] br = p4 + (32'($signed(ins[15:0])) << 2);
    nxt = p4; we = 1'b0; idx = 5'd31; flt = 1'b0; tag = "R2";
    if (op == 6'h02 || op == 6'h03) begin
      nxt = {p4[31:28], ins[25:0], 2'b00};
      we  = (op == 6'h03);
      tag = (op == 6'h03) ? "R4" : "R3";
    end else if (op == 6'h04) begin
      nxt = (rs == rt) ? br : p4; tag = "R5";
    end else if (op == 6'h05) begin
      nxt = (rs != rt) ? br : p4; tag = "R6";
    end else if (op == 6'h00 && (fn == 6'h08 || fn == 6'h09)) begin
      if (rs[1:0] != 2'b00) begin
        flt = 1'b1; nxt = pc; tag = "R9";
      end else begin
        nxt = rs;
        we  = (fn == 6'h09);
        idx = ins[15:11];
        tag = (fn == 6'h09) ? "R8" : "R7";
      end
    end
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] rs, input logic [31:0] rt);
    logic [31:0] expNext;
    logic        expWe, expFlt;
    logic [4:0]  expIdx;
    string       tag;
    instr = ins; rsVal = rs; rtVal = rt;
    #1;
    model(modelPc, ins, rs, rt, expNext, expWe, expIdx, expFlt, tag);
    check(nextPc == expNext, {tag, " nextPc"}, nextPc, expNext);
    check(linkWe == expWe, {tag, " linkWe"}, 32'(linkWe), 32'(expWe));
    check(misalignFault == expFlt, {tag, " R11 fault"}, 32'(misalignFault), 32'(expFlt));
    if (expWe) begin
      check(linkIdx == expIdx, {tag, " linkIdx"}, 32'(linkIdx), 32'(expIdx));
      check(linkVal == modelPc + 32'd4, {tag, " linkVal"}, linkVal, modelPc + 32'd4);
    end
    @(posedge clk);
    @(negedge clk);
    check(pcOut == expNext, {tag, " R10 pcOut after edge"}, pcOut, expNext);
    modelPc = expNext;
  endtask

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rd,
                                       input logic [5:0] fn);
    return {6'h00, rs, 5'd0, rd, 5'd0, fn};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pcOut == 32'h0000_1000, "R1 pc in reset", pcOut, 32'h0000_1000);
    rstN = 1'b1;
    #1;
    check(pcOut == 32'h0000_1000, "R1 pc after release", pcOut, 32'h0000_1000);

    // Directed corner cases
    step(encI(6'h09, 5'd1, 5'd2, 16'h0010), 32'h5, 32'h6);               // R2 addiu
    step(encI(6'h04, 5'd1, 5'd2, 16'hFFFD), 32'hAB, 32'hAB);             // R5 taken backward
    step(encI(6'h04, 5'd1, 5'd2, 16'h0040), 32'hAB, 32'hAC);             // R5 not taken
    step(encI(6'h05, 5'd1, 5'd2, 16'h0008), 32'h1, 32'h2);               // R6 taken
    step(encI(6'h05, 5'd1, 5'd2, 16'h0008), 32'h7, 32'h7);               // R6 not taken
    step(encR(5'd3, 5'd0, 6'h08), 32'hF000_0100, 32'h0);                 // R7 jr high region
    step({6'h02, 26'h0000_123}, 32'h0, 32'h0);                           // R3 keeps top nibble F
    step({6'h03, 26'h0000_400}, 32'h0, 32'h0);                           // R4 jal
    step(encR(5'd5, 5'd5, 6'h09), 32'h0000_2000, 32'h0);                 // R8 rd == rs
    step(encR(5'd4, 5'd0, 6'h08), 32'h0000_2002, 32'h0);                 // R9 jr misaligned
    step(encR(5'd4, 5'd9, 6'h09), 32'h0000_3001, 32'h0);                 // R9 jalr misaligned
    step(encR(5'd1, 5'd2, 6'h21), 32'h3, 32'h3);                         // R2 addu

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rs = $urandom;
      logic [31:0] rt = $urandom;
      logic [31:0] ins;
      int          kind = int'($urandom % 8);
      case (kind)
        0: begin
          logic [5:0] ops[8] = '{6'h09, 6'h0a, 6'h0d, 6'h0f, 6'h23, 6'h2b, 6'h20, 6'h28};
          ins = encI(ops[$urandom % 8], 5'($urandom), 5'($urandom), 16'($urandom));
        end
        1: begin
          logic [5:0] fns[5] = '{6'h00, 6'h21, 6'h24, 6'h2a, 6'h0c};
          ins = {6'h00, 20'($urandom), fns[$urandom % 5]};
        end
        2: ins = {6'h02, 26'($urandom)};
        3: ins = {6'h03, 26'($urandom)};
        4, 5: begin
          ins = encI(kind == 4 ? 6'h04 : 6'h05, 5'($urandom), 5'($urandom), 16'($urandom));
          if ($urandom % 2 == 0) rt = rs;
        end
        6: begin
          ins = {6'h00, 5'($urandom), 5'd0, 5'($urandom), 5'd0, ($urandom % 2) ? 6'h09 : 6'h08};
          rs[1:0] = 2'b00;
        end
        default: begin
          ins = {6'h00, 5'($urandom), 5'd0, 5'($urandom), 5'd0, ($urandom % 2) ? 6'h09 : 6'h08};
          if (rs[1:0] == 2'b00) rs[0] = 1'b1;
        end
      endcase
      step(ins, rs, rt);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule